// File: doc/BRIEF.md
# Non-Nesting Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt request lines into one interrupt output for a processor. Each line has its own enable bit in a mask register, and one global enable bit gates every line. A line is pending when its request input is high and its mask bit is set. When the global enable is on, no service is in progress and at least one line is pending, the controller enters service. It records the lowest-numbered pending line in a cause register and raises the interrupt output.

Once in service the controller accepts no further interrupt from any line until the handler gives an end-of-interrupt strobe, so handlers never nest. The cause register holds the serviced line number until the next entry. Because requests are levels, a line that is still high after end-of-interrupt is served again.

Top module: `irq_guard_ctrl`

## Requirements
- R1: While reset is asserted, and until the first write, irq_o is 0, cause_o is 0, mask_o is all zeros and gie_o is 0.
- R2: A mask_we_i or gie_we_i strobe loads mask_wdata_i or gie_wdata_i into mask_o or gie_o at the next clock edge. Without a strobe both registers hold their value.
- R3: pending_o bit i equals req_i bit i AND mask_o bit i, with no delay.
- R4: irq_o rises at the clock edge where, in the cycle before, gie_o was 1, irq_o was 0 and pending_o was nonzero. It never rises otherwise.
- R5: On entry, cause_o takes the index of the lowest-numbered set bit of pending_o. Bit 0 has the highest priority.
- R6: While irq_o is 1 and eoi_i is 0, irq_o stays 1 and cause_o does not change, whatever happens on req_i, the mask or the global enable.
- R7: An eoi_i pulse while irq_o is 1 clears irq_o at the next clock edge. No new entry happens at that same edge. An eoi_i pulse while irq_o is 0 has no effect.
- R8: A line that is still pending after end-of-interrupt is entered again one clock edge after irq_o has fallen.
- R9: A global enable of 0, or a mask bit of 0, keeps the affected lines from ever causing an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 16 | Level-sensitive request lines |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 16 | New mask value |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | New global enable value |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt to the CPU, high while in service |
| cause_o | output | 4 | Index of the line being serviced |
| pending_o | output | 16 | Requests that pass the mask |
| mask_o | output | 16 | Current mask register |
| gie_o | output | 1 | Current global enable |

## Verification
pending_o is combinational and is valid in the same cycle as req_i. Mask and enable writes show up one edge after the strobe, and entry, cause capture and release all happen one edge after their qualifying cycle. A write that enables a line therefore leads to entry two edges later. The bench drives inputs on the falling edge, steps a cycle model one rising edge at a time, and compares all outputs at the following falling edge. Each result is checked only in the cycle the model says it is due.

// File: rtl/irq_guard_pkg.sv
package irq_guard_pkg;
  localparam int unsigned IRQ_LINES = 16;
  localparam int unsigned IRQ_IDX_W = $clog2(IRQ_LINES);
  typedef logic [IRQ_LINES-1:0] irq_vec_t;
  typedef logic [IRQ_IDX_W-1:0] irq_idx_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  input  logic         gie_we_i,
  input  logic         gie_wdata_i,
  output logic [N-1:0] mask_o,
  output logic         gie_o
);
  logic [N-1:0] mask_q, mask_d;
  logic         gie_q, gie_d;

  always_comb begin
    mask_d = mask_q;
    gie_d  = gie_q;
    if (mask_we_i) mask_d = mask_wdata_i;
    if (gie_we_i)  gie_d  = gie_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d;
      if (gie_we_i)  gie_q  <= gie_d;
    end
  end

  assign mask_o = mask_q;
  assign gie_o  = gie_q;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(mask_wdata_i)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q)); // R2
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned N = 16,
  parameter int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | pend_i[g];
    assign grant[g]  = pend_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = idx_o | W'(i);
    end
  end

  assign any_o = seen[N];

  AST_WINNER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> pend_i[idx_o]); // R5
  AST_NONE_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0)); // R5
endmodule

// File: rtl/irq_service_ctrl.sv
module irq_service_ctrl #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         any_i,
  input  logic [W-1:0] idx_i,
  input  logic         eoi_i,
  output logic         active_o,
  output logic [W-1:0] cause_o
);
  logic         act_q, act_d;
  logic [W-1:0] cause_q, cause_d;
  logic         cause_en;

  always_comb begin
    act_d    = act_q;
    cause_d  = cause_q;
    cause_en = 1'b0;
    if (act_q) begin
      if (eoi_i) act_d = 1'b0;
    end else if (enable_i && any_i) begin
      act_d    = 1'b1;
      cause_d  = idx_i;
      cause_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      act_q <= act_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign active_o = act_q;
  assign cause_o  = cause_q;

  AST_ENTRY_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(enable_i && any_i)); // R4
  AST_NO_NESTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !eoi_i) |=> (act_q && $stable(cause_q))); // R6
  AST_EOI_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && eoi_i) |=> !act_q); // R7
  AST_CAUSE_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> cause_q == $past(idx_i)); // R5
endmodule

// File: rtl/irq_guard_ctrl.sv
module irq_guard_ctrl
  import irq_guard_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_vec_t req_i,
  input  logic     mask_we_i,
  input  irq_vec_t mask_wdata_i,
  input  logic     gie_we_i,
  input  logic     gie_wdata_i,
  input  logic     eoi_i,
  output logic     irq_o,
  output irq_idx_t cause_o,
  output irq_vec_t pending_o,
  output irq_vec_t mask_o,
  output logic     gie_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  irq_vec_t   mask;
  logic       gie;
  irq_vec_t   pend;
  logic       any;
  irq_idx_t   win_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  irq_cfg_regs #(.N(IRQ_LINES)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .gie_we_i     (gie_we_i),
    .gie_wdata_i  (gie_wdata_i),
    .mask_o       (mask),
    .gie_o        (gie)
  );

  assign pend = req_i & mask;

  irq_lowest_pick #(.N(IRQ_LINES), .W(IRQ_IDX_W)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pend_i (pend),
    .any_o  (any),
    .idx_o  (win_idx)
  );

  irq_service_ctrl #(.W(IRQ_IDX_W)) u_svc (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .enable_i (gie),
    .any_i    (any),
    .idx_i    (win_idx),
    .eoi_i    (eoi_i),
    .active_o (irq_o),
    .cause_o  (cause_o)
  );

  assign pending_o = pend;
  assign mask_o    = mask;
  assign gie_o     = gie;

  AST_GATED_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> $past(gie_o && (pending_o != '0))); // R9
endmodule

// File: tb/irq_guard_ctrl_tb_top.sv
module irq_guard_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] req, mask_wdata;
  logic        mask_we, gie_we, gie_wdata, eoi;
  logic        irq;
  logic [3:0]  cause;
  logic [15:0] pending, mask;
  logic        gie;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] m_mask;
  logic        m_gie, m_ins;
  logic [3:0]  m_cause;

  always #10 clk = ~clk;

  irq_guard_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .gie_we_i(gie_we), .gie_wdata_i(gie_wdata), .eoi_i(eoi),
    .irq_o(irq), .cause_o(cause), .pending_o(pending),
    .mask_o(mask), .gie_o(gie)
  );

  function automatic logic [3:0] lowest(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = 4'(i);
    if (v == 0) lowest = 4'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R4 irq", {31'd0, irq}, {31'd0, m_ins});
    chk("R5 cause", {28'd0, cause}, {28'd0, m_cause});
    chk("R2 mask", {16'd0, mask}, {16'd0, m_mask});
    chk("R2 gie", {31'd0, gie}, {31'd0, m_gie});
    chk("R3 pending", {16'd0, pending}, {16'd0, req & m_mask});
  endtask

  task automatic step();
    logic [15:0] pnd;
    logic [15:0] n_mask;
    logic        n_gie, n_ins;
    logic [3:0]  n_cause;
    pnd     = req & m_mask;
    n_mask  = mask_we ? mask_wdata : m_mask;
    n_gie   = gie_we ? gie_wdata : m_gie;
    n_ins   = m_ins;
    n_cause = m_cause;
    if (m_ins) begin
      if (eoi) n_ins = 1'b0;
    end else if (m_gie && pnd != 0) begin
      n_ins   = 1'b1;
      n_cause = lowest(pnd);
    end
    @(posedge clk);
    @(negedge clk);
    m_mask = n_mask; m_gie = n_gie; m_ins = n_ins; m_cause = n_cause;
    check_all();
  endtask

  task automatic idle_inputs();
    mask_we = 0; gie_we = 0; eoi = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_ni = 0; req = 0; mask_wdata = 0; gie_wdata = 0;
    idle_inputs();
    m_mask = 0; m_gie = 0; m_ins = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    req = 16'hFFFF;
    #1;
    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 cause", {28'd0, cause}, 32'd0);
    chk("R1 mask", {16'd0, mask}, 32'd0);
    chk("R1 gie", {31'd0, gie}, 32'd0);
    req = 0;
    @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    check_all();

    // R2: configuration writes
    mask_we = 1; mask_wdata = 16'hFFFF; gie_we = 1; gie_wdata = 1;
    step(); idle_inputs();

    // R5: lowest pending wins
    req = 16'hA048;
    step();
    chk("R5 lowest cause", {28'd0, cause}, 32'd3);

    // R6: no nesting while in service
    req = 16'h0001;
    repeat (3) step();
    chk("R6 still in service", {31'd0, irq}, 32'd1);
    chk("R6 cause stable", {28'd0, cause}, 32'd3);

    // R7: release, no same-edge entry
    req = 16'h0009; eoi = 1;
    step(); eoi = 0;
    chk("R7 released", {31'd0, irq}, 32'd0);
    // R8: still-asserted line served again
    step();
    chk("R8 reentry", {31'd0, irq}, 32'd1);
    chk("R8 cause", {28'd0, cause}, 32'd0);

    // R7: EOI when idle has no effect
    req = 0; eoi = 1; step();
    step(); eoi = 0;
    chk("R7 idle eoi", {31'd0, irq}, 32'd0);

    // R9: global enable off
    gie_we = 1; gie_wdata = 0; step(); idle_inputs();
    req = 16'hFFFF;
    repeat (3) step();
    chk("R9 gie off", {31'd0, irq}, 32'd0);
    // R9: mask off
    mask_we = 1; mask_wdata = 16'h0000; gie_we = 1; gie_wdata = 1;
    step(); idle_inputs();
    repeat (2) step();
    chk("R9 masked", {31'd0, irq}, 32'd0);
    mask_we = 1; mask_wdata = 16'h8000; step(); idle_inputs();
    step();
    chk("R9 enabled line", {31'd0, irq}, 32'd1);
    chk("R5 cause 15", {28'd0, cause}, 32'd15);
    eoi = 1; req = 0; step(); eoi = 0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      req = ($urandom % 4 == 0) ? 16'($urandom) : (16'($urandom) & 16'($urandom) & 16'($urandom));
      mask_we = (r[3:0] == 0);
      mask_wdata = 16'($urandom);
      gie_we = (r[8:4] == 0);
      gie_wdata = r[9];
      eoi = (r[12:10] == 0);
      step();
    end
    idle_inputs();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule